// File: doc/BRIEF.md
# Serial Flash Command Interface Front-End

This block is the slave side of the four-wire serial link of a flash device. Chip select, serial clock and serial data in arrive as pins and are sampled by the chip's own system clock. A configurable synchronizer chain feeds edge detectors, which then drive all shifting. At the start of each transaction the block records the clock polarity the host is using. It then shifts in an 8-bit opcode and a fixed number of address bytes, most significant bit first. It hands these to a command layer as held registers with one-cycle strobes, and gives a strobe for every received byte.

When the command layer has decoded a read, it raises a request to start data-out. At the next byte boundary the front-end starts to drive the serial output. It takes bytes from the command layer through a one-byte holding register with a valid/ready handshake. The inbound byte stream has no ready: the host clock cannot be stalled, so the command layer must accept every strobe. On the outbound side, ready is high while the holding register is empty and a transaction is active. Data is accepted on any cycle with valid and ready both high. If the host clocks a byte out before any byte has been supplied, the block sends all ones.

A separate active-low reset pin clears the transaction state and the held command registers.

Top module: `flash_spi_frontend`

## Requirements
- R1: After system reset the block reports mode 3 (`mode3`=1), holds `so_oe` low and pulses no strobe. It accepts bits only after a new falling edge of `cs_n`.
- R2: At each falling edge of `cs_n`, `mode3` takes the level of `sck` at that moment: 0 for mode 0 (idle low), 1 for mode 3 (idle high).
- R3: `si` is captured on rising `sck` edges, MSB first. After the 8th bit of a transaction, `opcode` holds the byte and `op_valid` pulses once.
- R4: The next ADDR_BYTES bytes are packed MSB first into `addr`, with the first address byte in the top bits. `addr_valid` pulses once, after the last of them.
- R5: Every completed byte, data bytes after the address included, appears on `rx_byte` with a one-cycle `rx_valid` pulse.
- R6: Output changes only on falling `sck` edges, MSB first. `so_oe` is high only in the data-out phase. That phase starts at the first falling edge at a byte boundary on which `dout_go` is high and at least the opcode has been received.
- R7: An outbound byte is accepted when `tx_valid` and `tx_ready` are both high, and the bytes are sent in order of acceptance. If no byte is held when a new output byte starts, 8'hFF is sent.
- R8: A rising edge of `cs_n` ends the transaction: `so_oe` falls and the bit and byte counts restart, so the next transaction begins with a fresh opcode.
- R9: While `pin_rst_n` is low, `opcode`, `addr`, the counters and the output are cleared and `mode3` returns to 1. Bits clocked after release count only after a new falling edge of `cs_n`.
- R10: A transaction that ends before its 8th rising edge produces no `op_valid` and no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the pins |
| rst_n | input | 1 | System reset, active low, asynchronous |
| pin_rst_n | input | 1 | Device reset pin, active low |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| so_d | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the serial data out; low means high impedance |
| mode3 | output | 1 | Clock mode taken at the last chip select fall (1 = mode 3) |
| opcode | output | 8 | Last received opcode |
| op_valid | output | 1 | One-cycle strobe when an opcode is received |
| addr | output | 8*ADDR_BYTES | Assembled address |
| addr_valid | output | 1 | One-cycle strobe when the address is complete |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for each received byte |
| dout_go | input | 1 | Command layer request to start the data-out phase |
| tx_data | input | 8 | Outbound byte |
| tx_valid | input | 1 | Outbound byte valid |
| tx_ready | output | 1 | Holding register can take a byte |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer and three address bytes. The serial clock runs at 16 system clocks per bit, so both synchronized edges and the command layer's reaction to `addr_valid` fall well inside a half period. With these values, the bench can cover random opcodes, addresses and data lengths in both clock modes. It also covers reads that run past the supplied bytes into the all-ones fill, aborts mid-byte, and a reset-pin pulse with chip select held low.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/fsf_sync.sv
module fsf_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= INIT;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= {STAGES{INIT}};
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fsf_rx.sv
module fsf_rx import fsf_pkg::*; #(
  parameter int ADDR_BYTES = 3,
  localparam int AW = BYTE_W * ADDR_BYTES,
  localparam int CW = $clog2(ADDR_BYTES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_cmd,
  input  logic              idle,
  input  logic              bit_rise,
  input  logic              din,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] opcode,
  output logic              op_valid,
  output logic [AW-1:0]     addr,
  output logic              addr_valid,
  output logic              at_boundary,
  output logic              hdr_seen
);
  localparam logic [CW-1:0] LAST_HDR = CW'(ADDR_BYTES);

  logic [2:0]        bcnt;
  logic [6:0]        sh;
  logic [CW-1:0]     nbytes;
  logic [BYTE_W-1:0] full;

  assign full        = {sh, din};
  assign at_boundary = (bcnt == 3'd0);
  assign hdr_seen    = (nbytes != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0; sh <= '0; nbytes <= '0;
      rx_byte <= '0; rx_valid <= 1'b0;
      opcode <= '0; op_valid <= 1'b0;
      addr <= '0; addr_valid <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      op_valid   <= 1'b0;
      addr_valid <= 1'b0;
      if (clr_cmd) begin
        opcode  <= '0;
        addr    <= '0;
        rx_byte <= '0;
      end
      if (idle) begin
        bcnt   <= '0;
        sh     <= '0;
        nbytes <= '0;
      end else if (bit_rise) begin
        bcnt <= bcnt + 3'd1;
        sh   <= full[6:0];
        if (bcnt == 3'd7) begin
          rx_byte  <= full;
          rx_valid <= 1'b1;
          if (nbytes == '0) begin
            opcode   <= full;
            op_valid <= 1'b1;
          end else if (nbytes <= LAST_HDR) begin
            addr       <= (addr << BYTE_W) | AW'(full);
            addr_valid <= (nbytes == LAST_HDR);
          end
          if (nbytes <= LAST_HDR) nbytes <= nbytes + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fsf_tx.sv
module fsf_tx import fsf_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              bit_fall,
  input  logic              start_ok,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              so_d,
  output logic              so_oe
);
  logic              out_on;
  logic [2:0]        tcnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] hold;
  logic              hold_full;
  logic [BYTE_W-1:0] next_byte;

  assign tx_ready  = !idle && !hold_full;
  assign next_byte = hold_full ? hold : FILL_BYTE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_on <= 1'b0; tcnt <= '0; sh <= '0;
      hold <= '0; hold_full <= 1'b0;
      so_d <= 1'b0; so_oe <= 1'b0;
    end else if (idle) begin
      out_on    <= 1'b0;
      tcnt      <= '0;
      hold_full <= 1'b0;
      so_oe     <= 1'b0;
      so_d      <= 1'b0;
    end else begin
      if (tx_valid && tx_ready) begin
        hold      <= tx_data;
        hold_full <= 1'b1;
      end
      if (bit_fall && (out_on || start_ok)) begin
        out_on <= 1'b1;
        so_oe  <= 1'b1;
        tcnt   <= tcnt + 3'd1;
        if (tcnt == 3'd0) begin
          so_d <= next_byte[BYTE_W-1];
          sh   <= {next_byte[BYTE_W-2:0], 1'b0};
          if (hold_full) hold_full <= 1'b0;
        end else begin
          so_d <= sh[BYTE_W-1];
          sh   <= {sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/flash_spi_frontend.sv
module flash_spi_frontend import fsf_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BYTES  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pin_rst_n,
  input  logic                         cs_n,
  input  logic                         sck,
  input  logic                         si,
  output logic                         so_d,
  output logic                         so_oe,
  output logic                         mode3,
  output logic [BYTE_W-1:0]            opcode,
  output logic                         op_valid,
  output logic [BYTE_W*ADDR_BYTES-1:0] addr,
  output logic                         addr_valid,
  output logic [BYTE_W-1:0]            rx_byte,
  output logic                         rx_valid,
  input  logic                         dout_go,
  input  logic [BYTE_W-1:0]            tx_data,
  input  logic                         tx_valid,
  output logic                         tx_ready
);
  localparam int NPINS = 4;
  localparam logic [NPINS-1:0] SYNC_INIT = 4'b0011;

  logic [NPINS-1:0] raw, synced;
  logic cs_s, sck_s, si_s, prst_n_s;
  logic cs_q, sck_q, armed, active;
  logic cs_fall, cs_rise, sck_rise, sck_fall;
  logic at_boundary, hdr_seen;

  assign raw = {pin_rst_n, si, sck, cs_n};

  genvar gi;
  generate
    for (gi = 0; gi < NPINS; gi++) begin : g_sync
      fsf_sync #(.STAGES(SYNC_STAGES), .INIT(SYNC_INIT[gi])) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw[gi]), .q(synced[gi]));
    end
  endgenerate

  assign {prst_n_s, si_s, sck_s, cs_s} = synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1; sck_q <= 1'b1; armed <= 1'b0; mode3 <= 1'b1;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
      if (!prst_n_s) begin
        armed <= 1'b0;
        mode3 <= 1'b1;
      end else if (cs_fall) begin
        armed <= 1'b1;
        mode3 <= sck_s;
      end else if (cs_rise) begin
        armed <= 1'b0;
      end
    end
  end

  assign cs_fall  = cs_q && !cs_s;
  assign cs_rise  = !cs_q && cs_s;
  assign active   = armed && !cs_s && prst_n_s;
  assign sck_rise = active && !sck_q && sck_s;
  assign sck_fall = active && sck_q && !sck_s;

  fsf_rx #(.ADDR_BYTES(ADDR_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr_cmd(!prst_n_s), .idle(!active),
    .bit_rise(sck_rise), .din(si_s),
    .rx_byte(rx_byte), .rx_valid(rx_valid),
    .opcode(opcode), .op_valid(op_valid),
    .addr(addr), .addr_valid(addr_valid),
    .at_boundary(at_boundary), .hdr_seen(hdr_seen));

  fsf_tx u_tx (
    .clk(clk), .rst_n(rst_n), .idle(!active), .bit_fall(sck_fall),
    .start_ok(dout_go && at_boundary && hdr_seen),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .so_d(so_d), .so_oe(so_oe));
endmodule

// File: rtl/flash_spi_frontend_chk.sv
module flash_spi_frontend_chk (
  input logic clk,
  input logic rst_n,
  input logic prst_n_s,
  input logic sck_s,
  input logic cs_fall,
  input logic cs_rise,
  input logic sck_rise,
  input logic sck_fall,
  input logic so_oe,
  input logic mode3,
  input logic op_valid,
  input logic addr_valid
);
  p_mode_at_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prst_n_s && cs_fall) |=> (mode3 == $past(sck_s)));

  p_op_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $past(sck_rise));

  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_valid, addr_valid}));

  p_drive_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> $past(sck_fall));

  p_release_on_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !so_oe);

  p_pin_reset_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !prst_n_s |=> ##1 (!so_oe && mode3));
endmodule

bind flash_spi_frontend flash_spi_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prst_n_s(prst_n_s), .sck_s(sck_s),
  .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_rise(sck_rise),
  .sck_fall(sck_fall), .so_oe(so_oe), .mode3(mode3),
  .op_valid(op_valid), .addr_valid(addr_valid));

// File: tb/flash_spi_frontend_tb.sv
`timescale 1ns/1ps
module flash_spi_frontend_tb;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pin_rst_n = 1'b1, cs_n = 1'b1, sck = 1'b1, si = 1'b0;
  logic so_d, so_oe, mode3, op_valid, addr_valid, rx_valid, tx_ready;
  logic [7:0] opcode, rx_byte, tx_data;
  logic [23:0] addr;
  logic dout_go = 1'b0, tx_valid = 1'b0;

  int checks = 0, errors = 0;
  int op_cnt = 0, addr_cnt = 0, rx_cnt = 0;
  logic [7:0] last_rx = 8'h00;
  logic [7:0] q [8];
  int q_n = 0, q_idx = 0;
  logic feed_en = 1'b0, rd_req = 1'b0, cur_m3 = 1'b1;
  logic oe_seen = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_spi_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so_d(so_d), .so_oe(so_oe), .mode3(mode3), .opcode(opcode), .op_valid(op_valid),
    .addr(addr), .addr_valid(addr_valid), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .dout_go(dout_go), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready));

  always @(posedge clk) begin
    if (op_valid) op_cnt <= op_cnt + 1;
    if (addr_valid) addr_cnt <= addr_cnt + 1;
    if (rx_valid) begin rx_cnt <= rx_cnt + 1; last_rx <= rx_byte; end
    if (cs_n) dout_go <= 1'b0;
    else if (addr_valid && rd_req) dout_go <= 1'b1;
  end

  always @(posedge clk) begin
    int nidx;
    nidx = q_idx + ((tx_valid && tx_ready) ? 1 : 0);
    q_idx <= nidx;
    tx_valid <= feed_en && (nidx < q_n);
    tx_data <= q[nidx % 8];
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_xfer(logic m3);
    cur_m3 = m3;
    cs_n = 1'b1; sck = m3; wclk(6);
    cs_n = 1'b0; wclk(H);
  endtask

  task automatic end_xfer();
    wclk(H); cs_n = 1'b1; sck = cur_m3; wclk(8);
  endtask

  task automatic xbit(logic b, output logic rb, output logic oe);
    if (cur_m3) begin
      sck = 1'b0; si = b; wclk(H);
      sck = 1'b1; rb = so_d; oe = so_oe; wclk(H);
    end else begin
      si = b; wclk(H);
      sck = 1'b1; rb = so_d; oe = so_oe; wclk(H);
      sck = 1'b0;
    end
  endtask

  task automatic xbyte(logic [7:0] b, output logic [7:0] rd, output logic all_oe, output logic any_oe);
    logic rb, oe;
    all_oe = 1'b1; any_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      xbit(b[i], rb, oe);
      rd[i] = rb; all_oe &= oe; any_oe |= oe;
    end
  endtask

  task automatic send_hdr(logic [7:0] op, logic [23:0] a, output logic any_oe);
    logic [7:0] rd; logic ao, yo;
    any_oe = 1'b0;
    xbyte(op, rd, ao, yo); any_oe |= yo;
    for (int k = 2; k >= 0; k--) begin
      xbyte(a[8*k +: 8], rd, ao, yo); any_oe |= yo;
    end
  endtask

  task automatic write_txn(logic m3, logic [7:0] op, logic [23:0] a, int nd);
    int o0, a0, r0; logic any_oe, ao, yo; logic [7:0] rd, d;
    o0 = op_cnt; a0 = addr_cnt; r0 = rx_cnt; d = 8'h00;
    begin_xfer(m3);
    check(mode3 == m3, "R2 mode at select", mode3, m3);
    send_hdr(op, a, any_oe);
    for (int i = 0; i < nd; i++) begin
      d = 8'($urandom);
      xbyte(d, rd, ao, yo); any_oe |= yo;
    end
    end_xfer();
    check(opcode == op && op_cnt == o0 + 1, "R3 opcode", opcode, op);
    check(addr == a && addr_cnt == a0 + 1, "R4 address", addr, a);
    check(rx_cnt == r0 + 4 + nd, "R5 byte strobes", rx_cnt - r0, 4 + nd);
    if (nd > 0) check(last_rx == d, "R5 last data byte", last_rx, d);
    check(!any_oe, "R6 no drive without read", any_oe, 0);
  endtask

  task automatic read_txn(logic m3, int nq, int nread, bit abort_mid);
    logic any_oe, ao, yo; logic [7:0] rd, exp;
    q_n = 0; q_idx = 0;
    for (int i = 0; i < nq; i++) q[i] = 8'($urandom);
    q_n = nq; rd_req = 1'b1;
    begin_xfer(m3);
    feed_en = 1'b1;
    send_hdr(8'h0B, 24'($urandom), any_oe);
    check(!any_oe, "R6 no drive in header", any_oe, 0);
    for (int i = 0; i < nread; i++) begin
      xbyte(8'h00, rd, ao, yo);
      exp = (i < nq) ? q[i] : 8'hFF;
      check(rd == exp, (i < nq) ? "R7 read byte order" : "R7 fill when empty", rd, exp);
      check(ao, "R6 drive during data-out", ao, 1);
    end
    if (abort_mid) begin
      xbit(1'b0, ao, yo); xbit(1'b0, ao, yo);
      check(so_oe, "R6 still driving mid-byte", so_oe, 1);
      cs_n = 1'b1; wclk(8);
      check(!so_oe, "R8 release on deselect mid-byte", so_oe, 0);
      sck = cur_m3; wclk(4);
    end else begin
      end_xfer();
      check(!so_oe, "R8 release on deselect", so_oe, 0);
    end
    feed_en = 1'b0; rd_req = 1'b0; q_n = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ao, yo; logic [7:0] rd; int o0, r0;
    void'($urandom(32'h5EED1234));
    wclk(5); rst_n = 1'b1; wclk(8);
    // R1 reset state
    check(mode3 == 1'b1, "R1 mode after reset", mode3, 1);
    check(!so_oe, "R1 output released", so_oe, 0);
    check(op_cnt == 0 && rx_cnt == 0, "R1 no strobes", op_cnt + rx_cnt, 0);

    // directed corners, both modes
    write_txn(1'b0, 8'h00, 24'h000000, 0);
    write_txn(1'b1, 8'hFF, 24'hFFFFFF, 1);
    write_txn(1'b0, 8'h81, 24'h800001, 2);
    // random
    for (int t = 0; t < 10; t++)
      write_txn(1'($urandom), 8'($urandom), 24'($urandom), int'($urandom % 4));

    // reads
    read_txn(1'b0, 3, 5, 0);
    read_txn(1'b1, 2, 3, 0);
    read_txn(1'b1, 0, 2, 0);
    read_txn(1'b0, 2, 1, 1);

    // R10 abort before 8th bit, R8 fresh start afterwards
    o0 = op_cnt; r0 = rx_cnt;
    begin_xfer(1'b0);
    for (int i = 0; i < 5; i++) xbit(1'b1, ao, yo);
    end_xfer();
    check(op_cnt == o0 && rx_cnt == r0, "R10 partial byte no strobe", op_cnt - o0, 0);
    write_txn(1'b1, 8'h3C, 24'h123456, 0);

    // R9 reset pin mid-transaction with select held low
    begin_xfer(1'b0);
    xbyte(8'hA5, rd, ao, yo);
    pin_rst_n = 1'b0; wclk(10);
    check(mode3 == 1'b1, "R9 mode back to 3", mode3, 1);
    check(opcode == 8'h00 && addr == 24'h0, "R9 command cleared", opcode, 0);
    check(!so_oe, "R9 output released", so_oe, 0);
    pin_rst_n = 1'b1; wclk(8);
    o0 = op_cnt; r0 = rx_cnt;
    for (int i = 0; i < 4; i++) xbyte(8'h5A, rd, ao, yo);
    check(op_cnt == o0 && rx_cnt == r0, "R9 ignored until new select", rx_cnt - r0, 0);
    end_xfer();
    write_txn(1'b0, 8'hD2, 24'h0ABCDE, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule